// File: doc/BRIEF.md
# Streaming 5x5 Gaussian Smoothing Filter

The block takes an 8-bit grayscale pixel stream in raster order, no more than one pixel every eight clocks, and returns one smoothed pixel for every pixel it accepts. A five-row by five-column moving window is held in tap registers. Four line FIFOs link the rows so that each row sees the same columns one image line earlier than the row below it. A small multiply-accumulate engine visits the window one row at a time with a single shared multiplier. It then adds the row results and divides by 256. The kernel is the outer product of the binomial weights 1, 4, 6, 4, 1, which sum to 256, so a flat image passes through unchanged.

The middle row and the middle column of the current window are brought out as ports, so that a spatial-derivative unit can reuse the same line storage. Window positions that would need pixels from outside the frame are not replicated. Their results are simply not flagged valid. A pixel that arrives while the engine is still working on the previous one breaks the input contract. It is dropped and reported on an error output.

Top module: `gauss_smooth5`

## Requirements
- R1: After each accepted pixel, where the newest pixel sits at line y and column x, element c of `mid_row` (bits [8c+7:8c]) holds the pixel at line y-2, column x-c, and element r of `mid_col` (bits [8r+7:8r]) holds the pixel at line y-r, column x-2. Lines are LINE_W pixels long.
- R2: The smoothed value equals floor(sum over i,j of w[i]*w[j]*p[i][j] / 256), with w = 1, 4, 6, 4, 1 over the 5x5 neighbourhood centred on line y-2, column x-2.
- R3: The arithmetic never overflows. An all-255 image gives 255, and a flat image of any level gives the same level.
- R4: `out_valid` is raised only for a pixel whose line index (counted from the pixel carrying `in_sof`) is at least 4 and whose column index is at least 4. No other pixel ever yields a valid result.
- R5: The result of a pixel accepted on clock edge t is presented with `out_valid` high for exactly one cycle, following edge t+6.
- R6: A pixel presented with `in_sof` high is taken as line 0, column 0. Line and column counting restarts from it, whatever came before.
- R7: A pixel presented on any of the six edges t+1 to t+6 after an accepted pixel raises `err_o` for the following cycle. It is dropped, and it has no effect on the window taps, the position count or any later result.
- R8: After reset, `out_valid` and `err_o` are low and both tap outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_pix | input | 8 | Input pixel |
| in_valid | input | 1 | Input pixel strobe |
| in_sof | input | 1 | Marks the first pixel of a frame, qualified by in_valid |
| out_pix | output | 8 | Smoothed pixel |
| out_valid | output | 1 | One-cycle strobe for out_pix |
| err_o | output | 1 | Pixel arrived while the engine was busy |
| mid_row | output | 40 | Five taps of the window's middle row |
| mid_col | output | 40 | Five taps of the window's middle column |

## Verification
The assertions assume only that reset is applied before traffic. The checker keeps its own count of cycles since the last pixel the block should have accepted, and from that count it derives the busy window, the result strobe timing and the periods during which the taps must hold. The stimulus normally spaces pixels exactly eight clocks apart, which keeps it inside the contract. Deliberate overlaps are injected three and six clocks after a pixel, so that both the error path and the proof that the dropped pixel left no trace are exercised.

// File: rtl/gauss_pkg.sv
package gauss_pkg;
  // Kernel span in each direction; the binomial weights below assume 5.
  localparam int TAPS    = 5;
  localparam int MID     = TAPS / 2;
  // Sum of the 2-D weights is 2**(2*(TAPS-1)) = 256
  localparam int NORM_SH = 2 * (TAPS - 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW0,
    ST_ROW1,
    ST_ROW2,
    ST_ROW3,
    ST_ROW4,
    ST_SUM
  } mac_st_e;

  function automatic int binom_w(input int idx);
    case (idx)
      0, 4:    return 1;
      1, 3:    return 4;
      2:       return 6;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/gauss_row.sv
module gauss_row
  import gauss_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  input  logic [PIX_W-1:0]        din,
  output logic [TAPS*PIX_W-1:0]   taps
);
  // Element 0 is the newest pixel; each accepted pixel pushes the row by one.
  always_ff @(posedge clk) begin
    if (rst) begin
      taps <= '0;
    end else if (adv) begin
      taps <= {taps[(TAPS-1)*PIX_W-1:0], din};
    end
  end
endmodule

// File: rtl/gauss_line_fifo.sv
module gauss_line_fifo #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 634
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [PIX_W-1:0] din,
  output logic [PIX_W-1:0] dout
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PIX_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    end
  end

  // Read-first single-port delay line: the value read is the one written
  // DEPTH accepted pixels ago.
  always_ff @(posedge clk) begin
    if (adv) begin
      mem[ptr] <= din;
    end
    if (rst) begin
      dout <= '0;
    end else if (adv) begin
      dout <= mem[ptr];
    end
  end
endmodule

// File: rtl/gauss_mac.sv
module gauss_mac
  import gauss_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic                          win_ok,
  input  logic [TAPS*TAPS*PIX_W-1:0]    win,
  output logic                          busy,
  output logic [PIX_W-1:0]              res_pix,
  output logic                          res_valid
);
  localparam int ACC_W  = PIX_W + NORM_SH;
  localparam int RIDX_W = $clog2(TAPS);
  localparam int ROW_W  = TAPS * PIX_W;

  mac_st_e          state;
  logic             ok_q;
  logic [ACC_W-1:0] part [TAPS];
  logic [RIDX_W-1:0] ridx;
  logic [ROW_W-1:0] sel_row;
  logic [ACC_W-1:0] hsum;
  logic [ACC_W-1:0] prod;
  logic [ACC_W-1:0] total;

  assign busy = (state != ST_IDLE);

  // One window row per state: horizontal weighting by shifts and adds,
  // then the single shared multiplier applies the vertical weight.
  always_comb begin
    if (state >= ST_ROW0 && state <= ST_ROW4) begin
      ridx = RIDX_W'(int'(state) - int'(ST_ROW0));
    end else begin
      ridx = '0;
    end
    sel_row = win[ridx*ROW_W +: ROW_W];
    hsum = '0;
    for (int c = 0; c < TAPS; c++) begin
      hsum = hsum + ACC_W'(sel_row[c*PIX_W +: PIX_W]) * ACC_W'(binom_w(c));
    end
    prod = hsum * ACC_W'(binom_w(int'(ridx)));
    total = '0;
    for (int r = 0; r < TAPS; r++) begin
      total = total + part[r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ok_q      <= 1'b0;
      res_valid <= 1'b0;
      res_pix   <= '0;
      for (int r = 0; r < TAPS; r++) begin
        part[r] <= '0;
      end
    end else begin
      res_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_ROW0;
            ok_q  <= win_ok;
          end
        end
        ST_SUM: begin
          res_pix   <= PIX_W'(total >> NORM_SH);
          res_valid <= ok_q;
          state     <= ST_IDLE;
        end
        default: begin
          part[ridx] <= prod;
          state      <= mac_st_e'(int'(state) + 1);
        end
      endcase
    end
  end
endmodule

// File: rtl/gauss_smooth5.sv
module gauss_smooth5
  import gauss_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int LINE_W = 640
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PIX_W-1:0]      in_pix,
  input  logic                  in_valid,
  input  logic                  in_sof,
  output logic [PIX_W-1:0]      out_pix,
  output logic                  out_valid,
  output logic                  err_o,
  output logic [TAPS*PIX_W-1:0] mid_row,
  output logic [TAPS*PIX_W-1:0] mid_col
);
  localparam int FIFO_D = LINE_W - (TAPS + 1);
  localparam int COL_W  = $clog2(LINE_W);
  localparam int LN_W   = $clog2(TAPS);
  localparam int ROW_W  = TAPS * PIX_W;

  logic             busy;
  logic             accept;
  logic [COL_W-1:0] col, ncol;
  logic [LN_W-1:0]  line, nline;
  logic             win_ok;

  logic [ROW_W-1:0]           row_taps [TAPS];
  logic [PIX_W-1:0]           row_in   [TAPS];
  logic [TAPS*ROW_W-1:0]      win;

  assign accept = in_valid && !busy;

  // Position of the pixel being accepted, relative to the last frame start
  always_comb begin
    if (in_sof) begin
      ncol  = '0;
      nline = '0;
    end else if (col == COL_W'(LINE_W - 1)) begin
      ncol  = '0;
      nline = (line == LN_W'(TAPS - 1)) ? line : line + 1'b1;
    end else begin
      ncol  = col + 1'b1;
      nline = line;
    end
    win_ok = (nline == LN_W'(TAPS - 1)) && (ncol >= COL_W'(TAPS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col   <= COL_W'(LINE_W - 1);
      line  <= '0;
      err_o <= 1'b0;
    end else begin
      err_o <= in_valid && busy;
      if (accept) begin
        col  <= ncol;
        line <= nline;
      end
    end
  end

  assign row_in[0] = in_pix;

  for (genvar r = 0; r < TAPS; r++) begin : g_row
    gauss_row #(.PIX_W(PIX_W)) u_row (
      .clk  (clk),
      .rst  (rst),
      .adv  (accept),
      .din  (row_in[r]),
      .taps (row_taps[r])
    );
    if (r < TAPS - 1) begin : g_fifo
      gauss_line_fifo #(.PIX_W(PIX_W), .DEPTH(FIFO_D)) u_fifo (
        .clk  (clk),
        .rst  (rst),
        .adv  (accept),
        .din  (row_taps[r][(TAPS-1)*PIX_W +: PIX_W]),
        .dout (row_in[r+1])
      );
    end
    assign win[r*ROW_W +: ROW_W]       = row_taps[r];
    assign mid_col[r*PIX_W +: PIX_W]   = row_taps[r][MID*PIX_W +: PIX_W];
  end

  assign mid_row = row_taps[MID];

  gauss_mac #(.PIX_W(PIX_W)) u_mac (
    .clk       (clk),
    .rst       (rst),
    .start     (accept),
    .win_ok    (win_ok),
    .win       (win),
    .busy      (busy),
    .res_pix   (out_pix),
    .res_valid (out_valid)
  );
endmodule

// File: rtl/gauss_smooth5_chk.sv
module gauss_smooth5_chk
  import gauss_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  err_o,
  input logic                  out_valid,
  input logic [TAPS*PIX_W-1:0] mid_row,
  input logic [TAPS*PIX_W-1:0] mid_col
);
  localparam int BUSY_CYC = TAPS + 1;

  // Cycles since the last pixel the block should have taken (saturates)
  logic [3:0] gap;
  logic       take;

  assign take = in_valid && (gap >= 4'(BUSY_CYC));

  always_ff @(posedge clk) begin
    if (rst) begin
      gap <= 4'hF;
    end else if (take) begin
      gap <= '0;
    end else if (gap != 4'hF) begin
      gap <= gap + 1'b1;
    end
  end

  a_r7_err_on_busy: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !take) |=> err_o);

  a_r7_no_spurious_err: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && !take) |=> !err_o);

  a_r5_result_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (gap == 4'(BUSY_CYC)));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  a_r1_taps_hold: assert property (@(posedge clk) disable iff (rst)
    !take |=> ($stable(mid_row) && $stable(mid_col)));
endmodule

bind gauss_smooth5 gauss_smooth5_chk #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .err_o     (err_o),
  .out_valid (out_valid),
  .mid_row   (mid_row),
  .mid_col   (mid_col)
);

// File: tb/gauss_smooth5_test.sv
module gauss_smooth5_test;
  localparam int LW = 16;
  localparam int H  = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  in_pix = '0;
  logic        in_valid = 1'b0;
  logic        in_sof = 1'b0;
  logic [7:0]  out_pix;
  logic        out_valid;
  logic        err_o;
  logic [39:0] mid_row;
  logic [39:0] mid_col;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  gauss_smooth5 #(.PIX_W(8), .LINE_W(LW)) uut (
    .clk(clk), .rst(rst), .in_pix(in_pix), .in_valid(in_valid),
    .in_sof(in_sof), .out_pix(out_pix), .out_valid(out_valid),
    .err_o(err_o), .mid_row(mid_row), .mid_col(mid_col)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wt(input int i);
    case (i)
      0, 4: return 1;
      1, 3: return 4;
      2:    return 6;
      default: return 0;
    endcase
  endfunction

  function automatic int pat(input int kind, input int y, input int x);
    case (kind)
      0: return 200;
      1: return 255;
      2: return (x * 13 + y * 7) & 255;
      3: return (y == 3 && x == 6) ? 255 : 0;
      default: return ((x * 37 + y * 91 + x * y * 5) ^ 90) & 255;
    endcase
  endfunction

  function automatic int ref_smooth(input int kind, input int y, input int x);
    int s = 0;
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        s += wt(i) * wt(j) * pat(kind, y - 4 + i, x - 4 + j);
    return s / 256;
  endfunction

  // Send one frame; optionally inject an extra pixel inj clocks after each
  // pixel in column 6 (0 = no injection).
  task automatic send_frame(input int kind, input int nlines, input int inj, input string tag);
    for (int y = 0; y < nlines; y++) begin
      for (int x = 0; x < LW; x++) begin
        bit ok;
        bit do_inj;
        ok = (y >= 4) && (x >= 4);
        do_inj = (inj != 0) && (x == 6);
        @(negedge clk);
        in_pix   = 8'(pat(kind, y, x));
        in_valid = 1'b1;
        in_sof   = (y == 0 && x == 0);
        for (int k = 0; k < 7; k++) begin
          @(negedge clk);
          if (k == 0) begin
            in_valid = 1'b0;
            in_sof   = 1'b0;
            if (ok) begin
              for (int c = 0; c < 5; c++) begin
                chk(mid_row[c*8 +: 8] == 8'(pat(kind, y - 2, x - c)), "R1 mid_row",
                    mid_row[c*8 +: 8], pat(kind, y - 2, x - c));
                chk(mid_col[c*8 +: 8] == 8'(pat(kind, y - c, x - 2)), "R1 mid_col",
                    mid_col[c*8 +: 8], pat(kind, y - c, x - 2));
              end
            end
          end
          if (k == 1) chk(err_o == 1'b0, "R7 no error on legal spacing", err_o, 0);
          if (k == 3 && !(do_inj && inj == 3))
            chk(out_valid == 1'b0, "R5 no early result", out_valid, 0);
          if (do_inj && k == inj) begin
            chk(err_o == 1'b1, "R7 overlap flagged", err_o, 1);
            in_valid = 1'b0;
          end
          if (k == 6) begin
            chk(out_valid == ok, {"R4 valid flag ", tag}, out_valid, ok);
            if (ok)
              chk(out_pix == 8'(ref_smooth(kind, y, x)), {"R2 smoothed value ", tag},
                  out_pix, ref_smooth(kind, y, x));
          end
          if (do_inj && k == inj - 1) begin
            in_pix   = 8'hEE;
            in_valid = 1'b1;
          end
        end
      end
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 out_valid after reset", out_valid, 0);
    chk(err_o == 1'b0, "R8 err_o after reset", err_o, 0);
    chk(mid_row == '0, "R8 mid_row after reset", mid_row, 0);
    chk(mid_col == '0, "R8 mid_col after reset", mid_col, 0);
  endtask

  task automatic t_flat();
    send_frame(0, H, 0, "R3 flat 200");
  endtask

  task automatic t_saturate();
    send_frame(1, H, 0, "R3 all 255");
  endtask

  task automatic t_ramp();
    send_frame(2, H, 0, "R2 ramp");
  endtask

  task automatic t_impulse();
    send_frame(3, H, 0, "R2 impulse");
  endtask

  task automatic t_sof_restart();
    // partial frame, then a new frame must restart counting (R6)
    send_frame(2, 3, 0, "R6 partial frame");
    send_frame(4, H, 0, "R6 restart");
  endtask

  task automatic t_overlap();
    send_frame(4, H, 3, "R7 overlap at +3");
    send_frame(2, H, 6, "R7 overlap at +6");
  endtask

  initial begin
    t_reset();
    t_flat();
    t_saturate();
    t_ramp();
    t_impulse();
    t_sof_restart();
    t_overlap();
    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule